// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

The engine writes a rectangular window of pixels into memory. Software programs the window through a small word-addressed register port: a destination base, the pixels per line and the number of lines, and a gap in pixels that is stepped over after every line. With this setup the window can sit inside a wider frame buffer. Setting the start bit launches the transfer. In fill mode every pixel receives the programmed colour. In copy mode each pixel is first read from a packed source area, then written to the window. Pixels are 32-bit ARGB8888 or 16-bit RGB565.

Memory traffic uses a single-beat valid/ready channel. The engine raises `mem_valid` with address, write data, byte enables and direction, and holds all of them stable until the cycle in which `mem_ready` is high. That cycle completes the beat, and `mem_err` and `mem_rdata` are sampled in it. The memory side applies back-pressure by holding `mem_ready` low for as long as it needs. Software can stall a running transfer, resume it or abandon it. Four sticky flags are write-1-to-clear and can be masked onto one interrupt line.

Top module: `rect_fill_dma`

## Requirements
- R1: SIZE (word 3) carries pixels per line in bits 31:16 and line count in bits 15:0. Every pixel of the window is written exactly once, in line order. Pixel p of line l goes to DST + (l*(W+OFF)+p)*B, where DST is word 4, OFF is the low 16 bits of word 6, and B is 4 for 32-bit pixels and 2 for 16-bit pixels. Bytes in the gaps stay untouched.
- R2: CTRL (word 0) bit 4 selects the pixel format: 0 for 32-bit, 1 for 16-bit. In fill mode (CTRL bits 3:2 = 0) a 32-bit pixel receives COLOR (word 7) with all four byte enables set. A 16-bit pixel receives COLOR[15:0] (red 15:11, green 10:5, blue 4:0) on the half-word lane chosen by address bit 1, and only that lane's two byte enables are set.
- R3: In copy mode (CTRL bits 3:2 = 1), pixel k of the transfer is read from SRC + k*B, where SRC is word 5, and written unchanged to its window position.
- R4: A start request raises the configuration-error flag (FLAGS bit 2) and issues no memory request if either of two conditions holds: the mode is 2 or 3, or the width or height is zero. In that case the start bit stays 0.
- R5: Writing CTRL bit 0 = 1 while idle starts a transfer. CTRL bit 0 reads 1 while the engine runs and returns to 0 by itself on completion. Finishing the last pixel sets the complete flag (FLAGS bit 0).
- R6: Writing CTRL bit 0 = 0 while running abandons the transfer at the next pixel boundary. The pixels already written form a prefix of the normal order, the complete flag stays clear, and no further requests follow.
- R7: While CTRL bit 1 is set, no new memory request is issued and all position state is kept. Clearing the bit continues with the next pixel, so the final image matches an uninterrupted run.
- R8: A beat completed with `mem_err` high sets FLAGS bit 1 and stops the transfer. The failed write is not committed, and the start bit clears.
- R9: When the line whose zero-based index equals WMARK (word 8) finishes, FLAGS bit 3 is set.
- R10: Writing 1 to a FLAGS bit clears that flag; writing 0 leaves it unchanged. IEN (word 1) bits 3:0 enable the flags of the same positions. `irq` is high exactly when some enabled flag is set.
- R11: While `mem_valid` is high and `mem_ready` low, `mem_valid`, `mem_we`, `mem_addr`, `mem_wdata` and `mem_be` keep their values into the next cycle.
- R12: While the start bit reads 1, writes to SIZE, DST, SRC, offset, COLOR and the mode and format fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Error response, valid with `mem_ready` |
| irq | output | 1 | Masked OR of the flags |

## Verification
The hardest situations to reach are the ones where software acts in the middle of a window. Suspend and abort must land between pixels, possibly while a beat is stalled, and an error must hit one particular beat. The bench arms a suspend or abort a fixed number of cycles after start, with `mem_ready` throttled. It then checks that no request appears during the stall and that the written memory equals exactly a prefix of the expected pixel sequence. Error responses are injected on a chosen grant number. Underneath these targeted cases, a sweep covers every small geometry in both modes and both formats under three ready patterns.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  typedef enum logic [1:0] {
    MODE_FILL  = 2'd0,
    MODE_COPY  = 2'd1,
    MODE_CONV  = 2'd2,
    MODE_BLEND = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_NEXT,
    WK_READ,
    WK_WRITE
  } wk_state_e;

  localparam logic [3:0] RA_CTRL  = 4'd0;
  localparam logic [3:0] RA_IEN   = 4'd1;
  localparam logic [3:0] RA_FLAGS = 4'd2;
  localparam logic [3:0] RA_SIZE  = 4'd3;
  localparam logic [3:0] RA_DST   = 4'd4;
  localparam logic [3:0] RA_SRC   = 4'd5;
  localparam logic [3:0] RA_OFFS  = 4'd6;
  localparam logic [3:0] RA_COLOR = 4'd7;
  localparam logic [3:0] RA_WMARK = 4'd8;

  localparam int FLG_DONE  = 0;
  localparam int FLG_XERR  = 1;
  localparam int FLG_CERR  = 2;
  localparam int FLG_WMARK = 3;
  localparam int FLG_N     = 4;
endpackage

// File: rtl/rfd_regs.sv
module rfd_regs
  import rfd_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  input  logic             busy,
  input  logic             wk_done,
  input  logic             wk_err,
  input  logic             wk_line_end,
  input  logic [DIM_W-1:0] wk_line_idx,
  output logic             go,
  output logic             abort_req,
  output logic             susp,
  output logic             copy_mode,
  output logic             fmt16,
  output logic [DIM_W-1:0] width,
  output logic [DIM_W-1:0] height,
  output logic [DIM_W-1:0] offset,
  output logic [AW-1:0]    dst_base,
  output logic [AW-1:0]    src_base,
  output logic [DW-1:0]    color,
  output logic             irq
);
  logic [DIM_W-1:0] wmark_q;
  logic [1:0]       mode_q;
  logic [FLG_N-1:0] ien_q, flags_q, flag_set, flag_clr;
  logic             wr_ctrl, start_req, cfg_bad, cerr_set, wm_hit;
  mode_e            new_mode;

  assign wr_ctrl   = cfg_we && (cfg_addr == RA_CTRL);
  assign new_mode  = mode_e'(cfg_wdata[3:2]);
  assign cfg_bad   = (new_mode == MODE_CONV) || (new_mode == MODE_BLEND) ||
                     (width == '0) || (height == '0);
  assign start_req = wr_ctrl && cfg_wdata[0] && !busy;
  assign go        = start_req && !cfg_bad;
  assign cerr_set  = start_req && cfg_bad;
  assign wm_hit    = wk_line_end && (wk_line_idx == wmark_q);
  assign copy_mode = (mode_q == MODE_COPY);

  always_comb begin
    flag_set = '0;
    flag_set[FLG_DONE]  = wk_done;
    flag_set[FLG_XERR]  = wk_err;
    flag_set[FLG_CERR]  = cerr_set;
    flag_set[FLG_WMARK] = wm_hit;
    flag_clr = (cfg_we && cfg_addr == RA_FLAGS) ? cfg_wdata[FLG_N-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width <= '0; height <= '0; offset <= '0; wmark_q <= '0;
      dst_base <= '0; src_base <= '0; color <= '0;
      mode_q <= '0; fmt16 <= 1'b0; susp <= 1'b0;
      ien_q <= '0; flags_q <= '0; abort_req <= 1'b0;
    end else begin
      flags_q   <= (flags_q & ~flag_clr) | flag_set;
      abort_req <= busy ? (abort_req | (wr_ctrl && !cfg_wdata[0])) : 1'b0;
      if (wr_ctrl) begin
        susp <= cfg_wdata[1];
        if (!busy) begin
          mode_q <= cfg_wdata[3:2];
          fmt16  <= cfg_wdata[4];
        end
      end
      if (cfg_we && cfg_addr == RA_IEN)   ien_q   <= cfg_wdata[FLG_N-1:0];
      if (cfg_we && cfg_addr == RA_WMARK) wmark_q <= cfg_wdata[DIM_W-1:0];
      if (cfg_we && !busy) begin
        case (cfg_addr)
          RA_SIZE:  begin width <= cfg_wdata[2*DIM_W-1:DIM_W]; height <= cfg_wdata[DIM_W-1:0]; end
          RA_DST:   dst_base <= cfg_wdata[AW-1:0];
          RA_SRC:   src_base <= cfg_wdata[AW-1:0];
          RA_OFFS:  offset   <= cfg_wdata[DIM_W-1:0];
          RA_COLOR: color    <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq = |(flags_q & ien_q);

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RA_CTRL:  cfg_rdata[4:0] = {fmt16, mode_q, susp, busy};
      RA_IEN:   cfg_rdata[FLG_N-1:0] = ien_q;
      RA_FLAGS: cfg_rdata[FLG_N-1:0] = flags_q;
      RA_SIZE:  cfg_rdata[2*DIM_W-1:0] = {width, height};
      RA_DST:   cfg_rdata[AW-1:0] = dst_base;
      RA_SRC:   cfg_rdata[AW-1:0] = src_base;
      RA_OFFS:  cfg_rdata[DIM_W-1:0] = offset;
      RA_COLOR: cfg_rdata = color;
      RA_WMARK: cfg_rdata[DIM_W-1:0] = wmark_q;
      default:  cfg_rdata = '0;
    endcase
  end

  a_r4_cfg_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    cerr_set |=> !busy);
  a_r5_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wk_done |=> !busy);
  a_r8_err_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wk_err |=> !busy);
  a_r12_size_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(width) && $stable(height)));
endmodule

// File: rtl/rfd_walker.sv
module rfd_walker
  import rfd_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             abort_req,
  input  logic             susp,
  input  logic             copy_mode,
  input  logic             fmt16,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [DIM_W-1:0] offset,
  input  logic [AW-1:0]    dst_base,
  input  logic [AW-1:0]    src_base,
  input  logic [DW-1:0]    color,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [DW/8-1:0]  mem_be,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_err,
  output logic             busy,
  output logic             done,
  output logic             xfer_err,
  output logic             line_end,
  output logic [DIM_W-1:0] line_idx
);
  localparam int BE_W = DW / 8;
  localparam int HW   = DW / 2;

  wk_state_e        state_q;
  logic [DIM_W-1:0] px_q, ln_q;
  logic [AW-1:0]    cur_q, line_q, src_q, pix_bytes, stride, next_line;
  logic [DW-1:0]    buf_q, pix_val;
  logic [DIM_W:0]   span;
  logic [HW-1:0]    rd_half;
  logic             last_px, last_ln, wr_ok, in_beat;

  assign span      = {1'b0, width} + {1'b0, offset};
  assign pix_bytes = fmt16 ? AW'(2) : AW'(4);
  assign stride    = fmt16 ? (AW'(span) << 1) : (AW'(span) << 2);
  assign next_line = line_q + stride;
  assign last_px   = (px_q == width - DIM_W'(1));
  assign last_ln   = (ln_q == height - DIM_W'(1));
  assign rd_half   = src_q[1] ? mem_rdata[DW-1:HW] : mem_rdata[HW-1:0];

  assign busy      = (state_q != WK_IDLE);
  assign in_beat   = (state_q == WK_READ) || (state_q == WK_WRITE);
  assign mem_valid = in_beat;
  assign mem_we    = (state_q == WK_WRITE);
  assign mem_addr  = (state_q == WK_READ) ? src_q : cur_q;
  assign pix_val   = copy_mode ? buf_q : color;
  assign mem_wdata = fmt16 ? {2{pix_val[HW-1:0]}} : pix_val;

  always_comb begin
    if (!fmt16) mem_be = '1;
    else if (mem_addr[1]) mem_be = {{(BE_W/2){1'b1}}, {(BE_W/2){1'b0}}};
    else mem_be = {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}};
  end

  assign wr_ok    = (state_q == WK_WRITE) && mem_ready && !mem_err;
  assign done     = wr_ok && last_px && last_ln;
  assign line_end = wr_ok && last_px;
  assign line_idx = ln_q;
  assign xfer_err = in_beat && mem_ready && mem_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      px_q <= '0; ln_q <= '0;
      cur_q <= '0; line_q <= '0; src_q <= '0; buf_q <= '0;
    end else begin
      case (state_q)
        WK_IDLE: if (go) begin
          state_q <= WK_NEXT;
          px_q <= '0; ln_q <= '0;
          cur_q <= dst_base; line_q <= dst_base; src_q <= src_base;
        end
        WK_NEXT: begin
          if (abort_req) state_q <= WK_IDLE;
          else if (!susp) state_q <= copy_mode ? WK_READ : WK_WRITE;
        end
        WK_READ: if (mem_ready) begin
          if (mem_err) state_q <= WK_IDLE;
          else begin
            buf_q   <= fmt16 ? {2{rd_half}} : mem_rdata;
            state_q <= WK_WRITE;
          end
        end
        WK_WRITE: if (mem_ready) begin
          if (mem_err) state_q <= WK_IDLE;
          else begin
            src_q <= src_q + pix_bytes;
            if (last_px) begin
              if (last_ln) state_q <= WK_IDLE;
              else begin
                ln_q <= ln_q + DIM_W'(1);
                px_q <= '0;
                line_q <= next_line;
                cur_q <= next_line;
                state_q <= WK_NEXT;
              end
            end else begin
              px_q <= px_q + DIM_W'(1);
              cur_q <= cur_q + pix_bytes;
              state_q <= WK_NEXT;
            end
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)
                                   && $stable(mem_be) && $stable(mem_we)));
  a_r2_half_lane_be: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we && fmt16) |-> ($countones(mem_be) == BE_W/2));
  a_r1_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((ln_q < height) && (px_q < width)));
  a_r6_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == WK_NEXT) && abort_req) |=> !mem_valid);
endmodule

// File: rtl/rect_fill_dma.sv
module rect_fill_dma
  import rfd_pkg::*;
#(
  parameter int DIM_W = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW/8-1:0] mem_be,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          irq
);
  logic             busy, wk_done, wk_err, wk_line_end, go, abort_req, susp, copy_mode, fmt16;
  logic [DIM_W-1:0] wk_line_idx, width, height, offset;
  logic [AW-1:0]    dst_base, src_base;
  logic [DW-1:0]    color;

  rfd_regs #(.DIM_W(DIM_W), .AW(AW), .DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .wk_done(wk_done), .wk_err(wk_err),
    .wk_line_end(wk_line_end), .wk_line_idx(wk_line_idx),
    .go(go), .abort_req(abort_req), .susp(susp), .copy_mode(copy_mode), .fmt16(fmt16),
    .width(width), .height(height), .offset(offset),
    .dst_base(dst_base), .src_base(src_base), .color(color), .irq(irq)
  );

  rfd_walker #(.DIM_W(DIM_W), .AW(AW), .DW(DW)) walker_i (
    .clk(clk), .rst_n(rst_n),
    .go(go), .abort_req(abort_req), .susp(susp), .copy_mode(copy_mode), .fmt16(fmt16),
    .width(width), .height(height), .offset(offset),
    .dst_base(dst_base), .src_base(src_base), .color(color),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .busy(busy), .done(wk_done), .xfer_err(wk_err),
    .line_end(wk_line_end), .line_idx(wk_line_idx)
  );
endmodule

// File: tb/rect_fill_dma_tb_top.sv
module rect_fill_dma_tb_top;
  localparam logic [31:0] DST = 32'h400;
  localparam logic [31:0] SRC = 32'h100;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_we, mem_valid, mem_ready, mem_we, mem_err, irq;
  logic [3:0]  cfg_addr, mem_be;
  logic [31:0] cfg_wdata, cfg_rdata, mem_addr, mem_wdata, mem_rdata;

  rect_fill_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .irq(irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  int wr_count = 0, gcnt = 0, req_seen = 0, err_at = 0;
  logic err_arm = 1'b0, init_req = 1'b0;
  logic [1:0] rdy_mode = 2'd0;
  logic [31:0] mem [0:511];
  logic [31:0] expm [0:511];

  function automatic logic [31:0] init_word(int i);
    return {8'hA5, 8'(i), 16'(i * 40503)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_word(i);
      wr_count <= 0; gcnt <= 0; req_seen <= 0;
    end else begin
      if (mem_valid) req_seen <= req_seen + 1;
      if (mem_valid && mem_ready) begin
        gcnt <= gcnt + 1;
        if (mem_we && !mem_err) begin
          wr_count <= wr_count + 1;
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[10:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end
      end
    end
  end

  assign mem_rdata = mem[mem_addr[10:2]];
  assign mem_err   = err_arm && mem_valid && (gcnt == err_at);

  always @(negedge clk) begin
    case (rdy_mode)
      2'd0: mem_ready <= 1'b1;
      2'd1: mem_ready <= (cyc % 3) != 0;
      default: mem_ready <= (cyc % 2) == 0;
    endcase
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      cfg_read(4'd0, d);
      if (!d[0]) break;
    end
  endtask

  task automatic reset_mem();
    @(negedge clk); init_req = 1'b1;
    @(negedge clk); init_req = 1'b0;
    for (int i = 0; i < 512; i++) expm[i] = init_word(i);
  endtask

  task automatic exp_fill(input int mode, input int fmt, input int w, input int h,
                          input int off, input logic [31:0] color, input int n);
    int bpp = fmt ? 2 : 4;
    for (int k = 0; k < n; k++) begin
      int l = k / w;
      int p = k % w;
      logic [31:0] da = DST + 32'((l * (w + off) + p) * bpp);
      logic [31:0] sa = SRC + 32'(k * bpp);
      logic [31:0] sw = init_word(int'(sa[10:2]));
      logic [31:0] v = (mode == 0) ? color : (fmt ? {16'h0, (sa[1] ? sw[31:16] : sw[15:0])} : sw);
      if (fmt == 0) expm[da[10:2]] = v;
      else if (da[1]) expm[da[10:2]][31:16] = v[15:0];
      else expm[da[10:2]][15:0] = v[15:0];
    end
  endtask

  task automatic cmp_image(input string tag);
    int first = -1;
    for (int i = 0; i < 512; i++) if (mem[i] !== expm[i] && first < 0) first = i;
    if (first < 0) check(1'b1, tag, 32'h0, 32'h0);
    else check(1'b0, tag, mem[first], expm[first]);
  endtask

  function automatic logic [31:0] ctrlw(int fmt, int mode, int s, int st);
    return 32'((fmt << 4) | (mode << 2) | (s << 1) | st);
  endfunction

  task automatic setup(input int w, input int h, input int off, input logic [31:0] color, input int wm);
    cfg_write(4'd3, {16'(w), 16'(h)});
    cfg_write(4'd4, DST);
    cfg_write(4'd5, SRC);
    cfg_write(4'd6, 32'(off));
    cfg_write(4'd7, color);
    cfg_write(4'd8, 32'(wm));
  endtask

  logic [31:0] rd;
  int wc0, vis;

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    wait_cycles(4);
    rst_n = 1'b1;
    wait_cycles(1);

    // Reset state
    cfg_read(4'd0, rd); check(rd == 0, "R5 reset ctrl", rd, 0);
    cfg_read(4'd2, rd); check(rd == 0, "R10 reset flags", rd, 0);
    check(irq == 0 && mem_valid == 0, "R10 reset irq/valid", {30'h0, irq, mem_valid}, 0);

    // Sweep: both modes, both formats, small geometries (R1 R2 R3 R5 R9 R10)
    cfg_write(4'd1, 32'h0);
    for (int mode = 0; mode < 2; mode++)
      for (int fmt = 0; fmt < 2; fmt++)
        for (int w = 1; w <= 3; w++)
          for (int h = 1; h <= 3; h++)
            for (int off = 0; off <= 2; off++) begin
              logic [31:0] col = 32'h1234F81F ^ 32'((w << 8) | (h << 4) | off);
              rdy_mode = 2'((w + h + off + mode) % 3);
              reset_mem();
              exp_fill(mode, fmt, w, h, off, col, w * h);
              setup(w, h, off, col, 1);
              cfg_write(4'd0, ctrlw(fmt, mode, 0, 1));
              wait_idle();
              cmp_image(mode ? "R3 copy image" : "R2 fill image");
              check(wr_count == w * h, "R1 write count", 32'(wr_count), 32'(w * h));
              cfg_read(4'd2, rd);
              check(rd[3:0] == {(h >= 2), 3'b001}, "R9 R5 flags after run", rd, {28'h0, (h >= 2), 3'b001});
              check(irq == 1'b0, "R10 masked irq", {31'h0, irq}, 0);
              cfg_write(4'd2, 32'hF);
              cfg_read(4'd2, rd); check(rd == 0, "R10 w1c clear", rd, 0);
            end

    // Interrupt enable (R10)
    rdy_mode = 0; reset_mem(); setup(2, 1, 0, 32'hCAFE0001, 9);
    cfg_write(4'd1, 32'h1);
    cfg_write(4'd0, ctrlw(0, 0, 0, 1)); wait_idle();
    check(irq == 1'b1, "R10 enabled irq", {31'h0, irq}, 1);
    cfg_write(4'd2, 32'h2);
    check(irq == 1'b1, "R10 w1c other bit", {31'h0, irq}, 1);
    cfg_write(4'd2, 32'h1);
    check(irq == 1'b0, "R10 irq after clear", {31'h0, irq}, 0);
    cfg_write(4'd1, 32'h0);

    // Register lock while running (R12)
    rdy_mode = 1; reset_mem(); exp_fill(0, 0, 8, 4, 1, 32'h0BADF00D, 32);
    setup(8, 4, 1, 32'h0BADF00D, 9);
    cfg_write(4'd0, ctrlw(0, 0, 0, 1));
    cfg_write(4'd3, 32'h00010001);
    cfg_write(4'd4, 32'h0);
    cfg_write(4'd7, 32'h0);
    cfg_write(4'd0, ctrlw(1, 1, 0, 1));
    cfg_read(4'd3, rd); check(rd == 32'h00080004, "R12 size locked", rd, 32'h00080004);
    cfg_read(4'd0, rd); check(rd[4:0] == 5'b00001, "R12 mode locked", rd, 1);
    wait_idle();
    cmp_image("R12 image unaffected");
    check(wr_count == 32, "R12 write count", 32'(wr_count), 32);
    cfg_write(4'd2, 32'hF);

    // Suspend and resume (R7)
    rdy_mode = 0; reset_mem(); exp_fill(0, 1, 6, 2, 2, 32'h00007E0F, 12);
    setup(6, 2, 2, 32'h00007E0F, 9);
    cfg_write(4'd0, ctrlw(1, 0, 0, 1));
    wait_cycles(3);
    cfg_write(4'd0, ctrlw(1, 0, 1, 1));
    wait_cycles(2);
    wc0 = wr_count; vis = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (mem_valid) vis++; end
    check(vis == 0, "R7 no request while suspended", 32'(vis), 0);
    check(wr_count == wc0 && wc0 > 0 && wc0 < 12, "R7 count frozen", 32'(wr_count), 32'(wc0));
    cfg_read(4'd0, rd); check(rd[0] == 1'b1, "R7 still busy", rd, 32'h13);
    cfg_write(4'd0, ctrlw(1, 0, 0, 1));
    wait_idle();
    cmp_image("R7 image after resume");
    cfg_read(4'd2, rd); check(rd[0] == 1'b1, "R7 complete after resume", rd, 1);
    cfg_write(4'd2, 32'hF);

    // Abort (R6)
    rdy_mode = 1; reset_mem();
    setup(8, 8, 0, 32'h55AA33CC, 9);
    cfg_write(4'd0, ctrlw(0, 0, 0, 1));
    wait_cycles(20);
    cfg_write(4'd0, ctrlw(0, 0, 0, 0));
    wait_cycles(8);
    cfg_read(4'd0, rd); check(rd[0] == 1'b0, "R6 start cleared", rd, 0);
    vis = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_valid) vis++; end
    check(vis == 0, "R6 no request after abort", 32'(vis), 0);
    check(wr_count > 0 && wr_count < 64, "R6 partial count", 32'(wr_count), 32'd32);
    cfg_read(4'd2, rd); check(rd[0] == 1'b0, "R6 no complete flag", rd, 0);
    exp_fill(0, 0, 8, 8, 0, 32'h55AA33CC, wr_count);
    cmp_image("R6 prefix image");
    cfg_write(4'd2, 32'hF);

    // Error response (R8)
    rdy_mode = 0; reset_mem();
    setup(4, 2, 0, 32'h01020304, 9);
    cfg_write(4'd1, 32'h2);
    err_at = 2; err_arm = 1'b1;
    cfg_write(4'd0, ctrlw(0, 0, 0, 1));
    wait_idle();
    err_arm = 1'b0;
    cfg_read(4'd2, rd); check(rd[1:0] == 2'b10, "R8 error flag only", rd, 2);
    check(irq == 1'b1, "R8 error irq", {31'h0, irq}, 1);
    check(wr_count == 2, "R8 failed write not committed", 32'(wr_count), 2);
    exp_fill(0, 0, 4, 2, 0, 32'h01020304, 2);
    cmp_image("R8 image");
    cfg_write(4'd2, 32'hF); cfg_write(4'd1, 32'h0);

    // Configuration errors (R4)
    for (int c = 0; c < 4; c++) begin
      int w = (c == 0) ? 0 : 3;
      int h = (c == 1) ? 0 : 2;
      int mode = (c < 2) ? 0 : c;
      reset_mem();
      setup(w, h, 0, 32'h0, 9);
      cfg_write(4'd0, ctrlw(0, mode, 0, 1));
      wait_cycles(4);
      cfg_read(4'd2, rd); check(rd[3:0] == 4'b0100, "R4 config error flag", rd, 4);
      cfg_read(4'd0, rd); check(rd[0] == 1'b0, "R4 start stays clear", rd, 0);
      check(req_seen == 0, "R4 no memory request", 32'(req_seen), 0);
      cfg_write(4'd2, 32'hF);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule